// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver with Receive Buffer

This block receives asynchronous serial characters on a single input line and hands each completed character to the rest of the chip through a one-entry receive buffer. A programmable divider turns the system clock into an oversampling tick, and every bit on the line lasts sixteen ticks. A character starts with a low start bit. Then come 7, 8 or 9 data bits, least significant bit first, an optional odd or even parity bit, and one or two high stop bits. The format is chosen at run time through configuration inputs and is captured when each start bit is accepted.

Software or a consumer block waits for the interrupt pulse or the buffer-full flag. It then reads the buffer data and error flags, and pulses a read acknowledge to free the buffer. A receive enable input gates the detection of new start bits. A character that completes while the buffer is still full replaces the buffer contents and sets an overrun flag.

Top module: `uart_rx_core`

## Requirements
- R1: While `rx_en` is 0, a falling edge on `rxd` starts no character, and no interrupt and no buffer-full follow.
- R2: A low on `rxd` that is gone again at the middle of the start bit (oversampling tick 8) is discarded as a glitch, and no character is received.
- R3: `cfg_len` selects the data length: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 gives 9 bits. Bits are assembled LSB first into `buf_data[0]` upward, and the buffer bits above the length read 0.
- R4: `cfg_par` selects parity: 1 is even, 2 is odd, and 0 or 3 is no parity bit. A received parity bit that differs from the computed one sets `err_par`.
- R5: `cfg_stop2` = 0 expects one stop bit and 1 expects two. A low sample in any expected stop bit sets `err_frm`.
- R6: One bit lasts 16 x (`div_n` + 1) clock cycles. Every bit is sampled at its mid-bit tick, for any `div_n` from 0 to 255.
- R7: At the middle of the last stop bit the character is copied into the buffer. In the same cycle `buf_full` rises and `irq` pulses high for exactly one cycle.
- R8: If a character completes while `buf_full` is 1 and no acknowledge is given in that cycle, `err_ovr` is set and `buf_data` takes the new character.
- R9: A one-cycle `rd_ack` clears `buf_full`, `err_par`, `err_frm` and `err_ovr` on the next edge, unless a character completes in that same cycle.
- R10: After reset `buf_full`, all error flags, `irq` and `buf_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| rx_en | input | 1 | Receive enable; gates start-bit detection |
| cfg_len | input | 2 | Data length select (0:7, 1:8, 2/3:9 bits) |
| cfg_par | input | 2 | Parity select (1 even, 2 odd, 0/3 none) |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| div_n | input | 8 | Divider value n; tick every n+1 clocks |
| rd_ack | input | 1 | Read acknowledge, frees the buffer and clears flags |
| buf_data | output | 9 | Received character, zero-extended |
| buf_full | output | 1 | Buffer holds an unread character |
| err_par | output | 1 | Parity error flag |
| err_frm | output | 1 | Framing error flag |
| err_ovr | output | 1 | Overrun error flag |
| irq | output | 1 | One-cycle pulse on each buffer load |

## Verification
The bench sends a short low pulse that must be thrown away at the start-bit midpoint. A receiver that trusted the falling edge alone would raise an interrupt with garbage data. It runs each data length and checks that the upper buffer bits stay zero. A mis-counted length would shift the parity or stop bit into the data. It flips a parity bit, and it drives the first of two stop bits low, which a receiver checking only the last stop bit would miss. It also sends two characters without an acknowledge to expose a missing overrun flag or a buffer that keeps the stale byte. A character at the largest divider value exposes a divider that ignores its upper bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int MAX_BITS = 9;
    localparam int OVS      = 16;
    localparam int OVS_W    = $clog2(OVS);
    localparam int IDX_W    = $clog2(MAX_BITS + 1);
    localparam logic [OVS_W-1:0] MID_TICK  = OVS_W'(OVS / 2);
    localparam logic [OVS_W-1:0] LAST_TICK = OVS_W'(OVS - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;

    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len_sel);
        case (len_sel)
            2'd0:    return IDX_W'(6);
            2'd1:    return IDX_W'(7);
            default: return IDX_W'(8);
        endcase
    endfunction

    function automatic logic parity_used(input logic [1:0] par_sel);
        return (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
    endfunction

    function automatic logic parity_expect(input logic [MAX_BITS-1:0] data,
                                           input logic [1:0] par_sel);
        return (par_sel == PAR_ODD) ? ~(^data) : (^data);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div_n);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxd_s,
    input  logic                rx_en,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    output logic                done,
    output logic [MAX_BITS-1:0] data,
    output logic                par_bad,
    output logic                frm_bad,
    output logic                busy
);
    typedef struct packed {
        rx_state_e           st;
        logic [OVS_W-1:0]    ovs;
        logic [IDX_W-1:0]    bidx;
        logic                stop_idx;
        logic [MAX_BITS-1:0] sh;
        logic [1:0]          len;
        logic [1:0]          par;
        logic                stop2;
        logic                pbad;
        logic                fbad;
        logic                done;
        logic [MAX_BITS-1:0] dout;
        logic                pout;
        logic                fout;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   frm_now;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        frm_now   = fr_q.fbad | ~rxd_s;
        if (tick) begin
            if (fr_q.st == ST_IDLE) begin
                if (rx_en && !rxd_s) begin
                    fr_d.st       = ST_START;
                    fr_d.ovs      = OVS_W'(1);
                    fr_d.sh       = '0;
                    fr_d.pbad     = 1'b0;
                    fr_d.fbad     = 1'b0;
                    fr_d.stop_idx = 1'b0;
                    fr_d.len      = cfg_len;
                    fr_d.par      = cfg_par;
                    fr_d.stop2    = cfg_stop2;
                end
            end else begin
                fr_d.ovs = fr_q.ovs + 1'b1;
                case (fr_q.st)
                    ST_START: begin
                        if (fr_q.ovs == MID_TICK && rxd_s) begin
                            fr_d.st  = ST_IDLE;
                            fr_d.ovs = '0;
                        end else if (fr_q.ovs == LAST_TICK) begin
                            fr_d.st   = ST_DATA;
                            fr_d.bidx = '0;
                        end
                    end
                    ST_DATA: begin
                        if (fr_q.ovs == MID_TICK) begin
                            fr_d.sh[fr_q.bidx] = rxd_s;
                        end else if (fr_q.ovs == LAST_TICK) begin
                            if (fr_q.bidx == last_index(fr_q.len))
                                fr_d.st = parity_used(fr_q.par) ? ST_PAR : ST_STOP;
                            else
                                fr_d.bidx = fr_q.bidx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (fr_q.ovs == MID_TICK)
                            fr_d.pbad = rxd_s ^ parity_expect(fr_q.sh, fr_q.par);
                        else if (fr_q.ovs == LAST_TICK)
                            fr_d.st = ST_STOP;
                    end
                    ST_STOP: begin
                        if (fr_q.ovs == MID_TICK) begin
                            fr_d.fbad = frm_now;
                            if (fr_q.stop_idx == fr_q.stop2) begin
                                fr_d.st   = ST_IDLE;
                                fr_d.ovs  = '0;
                                fr_d.done = 1'b1;
                                fr_d.dout = fr_q.sh;
                                fr_d.pout = fr_q.pbad;
                                fr_d.fout = frm_now;
                            end
                        end else if (fr_q.ovs == LAST_TICK) begin
                            fr_d.stop_idx = 1'b1;
                        end
                    end
                    default: begin
                        fr_d.st  = ST_IDLE;
                        fr_d.ovs = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '{st: ST_IDLE, default: '0};
        else        fr_q <= fr_d;
    end

    assign done    = fr_q.done;
    assign data    = fr_q.dout;
    assign par_bad = fr_q.pout;
    assign frm_bad = fr_q.fout;
    assign busy    = (fr_q.st != ST_IDLE);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          load_perr,
    input  logic          load_ferr,
    input  logic          rd_ack,
    output logic [DW-1:0] buf_data,
    output logic          buf_full,
    output logic          err_par,
    output logic          err_frm,
    output logic          err_ovr,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          perr;
        logic          ferr;
        logic          ovr;
        logic          irq;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.irq = 1'b0;
        if (rd_ack) begin
            b_d.full = 1'b0;
            b_d.perr = 1'b0;
            b_d.ferr = 1'b0;
            b_d.ovr  = 1'b0;
        end
        if (load) begin
            b_d.data = load_data;
            b_d.full = 1'b1;
            b_d.perr = b_d.perr | load_perr;
            b_d.ferr = b_d.ferr | load_ferr;
            b_d.ovr  = b_d.ovr | (b_q.full & ~rd_ack);
            b_d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign buf_data = b_q.data;
    assign buf_full = b_q.full;
    assign err_par  = b_q.perr;
    assign err_frm  = b_q.ferr;
    assign err_ovr  = b_q.ovr;
    assign irq      = b_q.irq;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [1:0]          cfg_len,
    input  logic [1:0]          cfg_par,
    input  logic                cfg_stop2,
    input  logic [DIV_W-1:0]    div_n,
    input  logic                rd_ack,
    output logic [MAX_BITS-1:0] buf_data,
    output logic                buf_full,
    output logic                err_par,
    output logic                err_frm,
    output logic                err_ovr,
    output logic                irq
);
    logic                rxd_s;
    logic                tick;
    logic                fr_done;
    logic [MAX_BITS-1:0] fr_data;
    logic                fr_perr;
    logic                fr_ferr;
    logic                rx_busy;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div_n(div_n),
        .tick (tick)
    );

    uart_rx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rxd_s    (rxd_s),
        .rx_en    (rx_en),
        .cfg_len  (cfg_len),
        .cfg_par  (cfg_par),
        .cfg_stop2(cfg_stop2),
        .done     (fr_done),
        .data     (fr_data),
        .par_bad  (fr_perr),
        .frm_bad  (fr_ferr),
        .busy     (rx_busy)
    );

    uart_rx_buffer #(.DW(MAX_BITS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fr_done),
        .load_data(fr_data),
        .load_perr(fr_perr),
        .load_ferr(fr_ferr),
        .rd_ack   (rd_ack),
        .buf_data (buf_data),
        .buf_full (buf_full),
        .err_par  (err_par),
        .err_frm  (err_frm),
        .err_ovr  (err_ovr),
        .irq      (irq)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic rx_busy,
    input logic rd_ack,
    input logic buf_full,
    input logic err_par,
    input logic err_frm,
    input logic err_ovr,
    input logic irq
);
    // R1: a disabled receiver in idle stays idle
    p_idle_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rx_busy) |=> !rx_busy);

    // R7: interrupt and full flag rise together, interrupt lasts one cycle
    p_irq_with_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> buf_full);
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_full_rise_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |-> irq);

    // R8: overrun appears only on a load into an already full buffer
    p_ovr_on_full_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_ovr) |-> (irq && $past(buf_full)));

    // R9: acknowledge clears flags unless a new load arrives
    p_ack_clears_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> (!buf_full || irq));
    p_ack_clears_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> ((!err_par && !err_frm && !err_ovr) || irq));
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .rx_busy (rx_busy),
    .rd_ack  (rd_ack),
    .buf_full(buf_full),
    .err_par (err_par),
    .err_frm (err_frm),
    .err_ovr (err_ovr),
    .irq     (irq)
);

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] cfg_len = 2'd1;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic [7:0] div_n = 8'd3;
    logic       rd_ack = 1'b0;
    logic [8:0] buf_data;
    logic       buf_full, err_par, err_frm, err_ovr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_cnt = 0;
    int cur_n   = 3;

    always #2.5 clk = ~clk;

    uart_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .div_n(div_n), .rd_ack(rd_ack), .buf_data(buf_data),
        .buf_full(buf_full), .err_par(err_par), .err_frm(err_frm),
        .err_ovr(err_ovr), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int per);
        @(negedge clk) rxd = v;
        repeat (per - 1) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nbits, input logic [1:0] pm,
                        input bit flip_par, input bit two_stop, input bit bad_stop1);
        int  per = 16 * (cur_n + 1);
        logic p = 1'b0;
        drive_bit(1'b0, per);
        for (int i = 0; i < nbits; i++) begin
            drive_bit(d[i], per);
            p ^= d[i];
        end
        if (pm == 2'd1 || pm == 2'd2) begin
            if (pm == 2'd2) p = ~p;
            if (flip_par) p = ~p;
            drive_bit(p, per);
        end
        drive_bit(~bad_stop1, per);
        if (two_stop) drive_bit(1'b1, per);
        @(negedge clk) rxd = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 buf_full", buf_full, 0);
        check("R10 errors", {err_par, err_frm, err_ovr}, 0);
        check("R10 buf_data", buf_data, 0);
        check("R10 irq", irq_cnt, 0);
    endtask

    task automatic t_8n1();
        int c0 = irq_cnt;
        cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        send(9'h0A5, 8, 2'd0, 0, 0, 0);
        check("R3 8-bit data", buf_data, 9'h0A5);
        check("R7 buf_full", buf_full, 1);
        check("R7 one irq", irq_cnt - c0, 1);
        check("R6 no errors", {err_par, err_frm, err_ovr}, 0);
        ack();
        check("R9 ack clears full", buf_full, 0);
    endtask

    task automatic t_7e2();
        cfg_len = 2'd0; cfg_par = 2'd1; cfg_stop2 = 1'b1;
        send(9'h1DB, 7, 2'd1, 0, 1, 0);
        check("R3 7-bit data upper zero", buf_data, 9'h05B);
        check("R4 even parity ok", err_par, 0);
        check("R5 two stops ok", err_frm, 0);
        ack();
    endtask

    task automatic t_9o1();
        cfg_len = 2'd2; cfg_par = 2'd2; cfg_stop2 = 1'b0;
        send(9'h1C3, 9, 2'd2, 0, 0, 0);
        check("R3 9-bit data", buf_data, 9'h1C3);
        check("R4 odd parity ok", err_par, 0);
        ack();
    endtask

    task automatic t_par_err();
        cfg_len = 2'd1; cfg_par = 2'd1; cfg_stop2 = 1'b0;
        send(9'h037, 8, 2'd1, 1, 0, 0);
        check("R4 parity error", err_par, 1);
        check("R4 data kept", buf_data, 9'h037);
        ack();
        check("R9 ack clears parity", err_par, 0);
    endtask

    task automatic t_frm_err();
        cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop2 = 1'b1;
        send(9'h0F0, 8, 2'd0, 0, 1, 1);
        check("R5 first stop low", err_frm, 1);
        check("R5 data", buf_data, 9'h0F0);
        ack();
        check("R9 ack clears framing", err_frm, 0);
    endtask

    task automatic t_glitch();
        int c0 = irq_cnt;
        @(negedge clk) rxd = 1'b0;
        repeat (3 * (cur_n + 1)) @(negedge clk);
        rxd = 1'b1;
        repeat (40 * 16 * (cur_n + 1)) @(negedge clk);
        check("R2 glitch no irq", irq_cnt - c0, 0);
        check("R2 glitch no full", buf_full, 0);
    endtask

    task automatic t_disabled();
        int c0 = irq_cnt;
        rx_en = 1'b0;
        cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        send(9'h055, 8, 2'd0, 0, 0, 0);
        check("R1 disabled no irq", irq_cnt - c0, 0);
        check("R1 disabled no full", buf_full, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_overrun();
        int c0 = irq_cnt;
        cfg_len = 2'd1; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        send(9'h011, 8, 2'd0, 0, 0, 0);
        check("R8 no overrun on first", err_ovr, 0);
        send(9'h022, 8, 2'd0, 0, 0, 0);
        check("R8 overrun set", err_ovr, 1);
        check("R8 newest data", buf_data, 9'h022);
        check("R8 two irqs", irq_cnt - c0, 2);
        ack();
        check("R9 ack clears overrun", err_ovr, 0);
    endtask

    task automatic t_slow();
        cur_n = 255; div_n = 8'd255;
        cfg_len = 2'd0; cfg_par = 2'd0; cfg_stop2 = 1'b0;
        send(9'h02A, 7, 2'd0, 0, 0, 0);
        check("R6 divider 255 data", buf_data, 9'h02A);
        check("R6 divider 255 full", buf_full, 1);
        ack();
        cur_n = 3; div_n = 8'd3;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_8n1();
        t_7e2();
        t_9o1();
        t_par_err();
        t_frm_err();
        t_glitch();
        t_disabled();
        t_overrun();
        t_slow();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule